// File: doc/BRIEF.md
# Wavefront Execution Mask Controller

This block keeps the per-lane execution mask of one 64-lane wavefront and runs the scalar mask operations that implement divergent branches. A per-lane compare result comes in on `cmp_mask`. One operation is accepted per cycle. Save-and-AND narrows the mask to the lanes that take the if-part and keeps the old mask in a slot of a small saved-mask file. AND-NOT-saved switches to the else-part lanes. Restore brings the original mask back. A scalar condition flag reports whether any lane is still active. A test operation produces a branch-take pulse when the mask is empty, so the whole wavefront can skip a branch body.

Vector writes are issued as several narrow passes; with the defaults this is four passes of 16 lanes. A start pulse takes a snapshot of the mask, and the block then drives per-lane write enables for one slice per cycle. A lane whose mask bit is 0 never gets an enable. Saved slots are independent of each other, so conditions can be nested up to the depth of the file, and any slot can be read through a side port.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset, `exec_mask` is all ones, `scc`, `branch_take` and `wr_busy` are 0, `lane_we` is 0, and every saved slot reads 0.
- R2: Operation code 1 (save-and-AND) writes the current mask into slot `op_slot` and sets the mask to the old mask AND `cmp_mask`, visible after the next clock edge.
- R3: After operation codes 1 and 2, `scc` is 1 exactly when the new mask is nonzero; every other operation leaves `scc` unchanged.
- R4: Operation code 2 (AND-NOT-saved) sets the mask to slot `op_slot` AND the complement of the current mask.
- R5: Operation code 3 (restore) sets the mask to the content of slot `op_slot`.
- R6: Operation code 4 (load) sets the mask to `cmp_mask`.
- R7: Operation code 5 (test) raises `branch_take` for exactly the next cycle, at 1 only if the mask was all zero.
- R8: A `wr_start` pulse takes a snapshot of the mask as it was before that edge. For the next four cycles, `wr_busy` is 1, `pass_idx` counts 0,1,2,3, and `lane_we` equals snapshot bits [16*p+15:16*p] for pass p. After that, `wr_busy` returns to 0.
- R9: `lane_we` is 0 whenever `wr_busy` is 0, and a lane whose snapshot bit is 0 gets no enable in any pass.
- R10: A `wr_start` pulse while `wr_busy` is 1 is ignored; a mask change during the passes does not alter the enables.
- R11: With `op_valid` low, or with operation code 0, the mask, `scc` and the saved slots do not change.
- R12: An operation on one slot leaves the other saved slots unchanged, and at least four slots exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Mask operation valid this cycle |
| op_code | input | 3 | 0 none, 1 save-and-AND, 2 AND-NOT-saved, 3 restore, 4 load, 5 test |
| op_slot | input | 2 | Saved-mask slot used by the operation |
| cmp_mask | input | 64 | Per-lane compare result or load value |
| exec_mask | output | 64 | Current execution mask |
| scc | output | 1 | Scalar condition flag: mask nonzero |
| branch_take | output | 1 | One-cycle pulse: tested mask was empty |
| rd_slot | input | 2 | Saved slot selected for reading |
| rd_mask | output | 64 | Content of slot `rd_slot` |
| wr_start | input | 1 | Start a multi-pass write |
| wr_busy | output | 1 | Passes in progress |
| pass_idx | output | 2 | Current pass number |
| lane_we | output | 16 | Per-lane write enables for the current pass |

## Verification
The assertions assume that `op_valid` and `wr_start` are low throughout reset and that `op_code` holds only the six defined codes. The pulse and flag properties compare against the operation seen one cycle earlier. For that reason, the stimulus is driven on the falling edge, each operation is held for exactly one rising edge, and all inputs are cleared during reset. The vector table walks a nested if/else sequence through every slot, including the empty-mask cases that clear the flag.

// File: rtl/exec_mask_pkg.sv
package exec_mask_pkg;
   typedef enum logic [2:0] {
      EM_NOP          = 3'd0,
      EM_SAVE_AND     = 3'd1,
      EM_ANDN_SAVED   = 3'd2,
      EM_RESTORE      = 3'd3,
      EM_LOAD         = 3'd4,
      EM_TEST_EMPTY   = 3'd5
   } em_op_e;
endpackage

// File: rtl/exec_mask_alu.sv
module exec_mask_alu import exec_mask_pkg::*; #(
   parameter int LANES = 64
) (
   input  logic             valid,
   input  logic [2:0]       op,
   input  logic [LANES-1:0] cur,
   input  logic [LANES-1:0] saved,
   input  logic [LANES-1:0] cmp,
   output logic [LANES-1:0] nxt,
   output logic             mask_we,
   output logic             flag_we,
   output logic             save_we,
   output logic             test_req
);
   em_op_e op_e;
   assign op_e = em_op_e'(op);

   always_comb begin
      nxt      = cur;
      mask_we  = 1'b0;
      flag_we  = 1'b0;
      save_we  = 1'b0;
      test_req = 1'b0;
      if (valid) begin
         case (op_e)
            EM_SAVE_AND: begin
               nxt     = cur & cmp;
               mask_we = 1'b1;
               flag_we = 1'b1;
               save_we = 1'b1;
            end
            EM_ANDN_SAVED: begin
               nxt     = saved & ~cur;
               mask_we = 1'b1;
               flag_we = 1'b1;
            end
            EM_RESTORE: begin
               nxt     = saved;
               mask_we = 1'b1;
            end
            EM_LOAD: begin
               nxt     = cmp;
               mask_we = 1'b1;
            end
            EM_TEST_EMPTY: test_req = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/exec_save_file.sv
module exec_save_file #(
   parameter int LANES  = 64,
   parameter int DEPTH  = 4,
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] wslot,
   input  logic [LANES-1:0]  wdata,
   input  logic [SLOT_W-1:0] rslot_a,
   output logic [LANES-1:0]  rdata_a,
   input  logic [SLOT_W-1:0] rslot_b,
   output logic [LANES-1:0]  rdata_b
);
   logic [LANES-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[g] <= '0;
         else if (we && (wslot == SLOT_W'(g)))
            ent[g] <= wdata;
      end
   end

   assign rdata_a = ent[rslot_a];
   assign rdata_b = ent[rslot_b];
endmodule

// File: rtl/exec_pass_seq.sv
module exec_pass_seq #(
   parameter int LANES  = 64,
   parameter int PASS_W = 16,
   parameter int NPASS  = 4,
   parameter int IW     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LANES-1:0]  mask,
   output logic              busy,
   output logic [IW-1:0]     idx,
   output logic [PASS_W-1:0] lane_we
);
   logic [LANES-1:0]  snap;
   logic [PASS_W-1:0] slice [NPASS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         snap <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            snap <= mask;
         end
      end else if (idx == IW'(NPASS-1)) begin
         busy <= 1'b0;
         idx  <= '0;
      end else begin
         idx <= idx + 1'b1;
      end
   end

   for (genvar g = 0; g < NPASS; g++) begin : g_slice
      assign slice[g] = snap[g*PASS_W +: PASS_W];
   end

   assign lane_we = busy ? slice[idx] : '0;
endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl import exec_mask_pkg::*; #(
   parameter int LANES      = 64,
   parameter int PASS_W     = 16,
   parameter int SAVE_DEPTH = 4,
   localparam int NPASS     = LANES / PASS_W,
   localparam int IW        = (NPASS > 1) ? $clog2(NPASS) : 1,
   localparam int SLOT_W    = (SAVE_DEPTH > 1) ? $clog2(SAVE_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [SLOT_W-1:0] op_slot,
   input  logic [LANES-1:0]  cmp_mask,
   output logic [LANES-1:0]  exec_mask,
   output logic              scc,
   output logic              branch_take,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [LANES-1:0]  rd_mask,
   input  logic              wr_start,
   output logic              wr_busy,
   output logic [IW-1:0]     pass_idx,
   output logic [PASS_W-1:0] lane_we
);
   initial begin
      assert (LANES % PASS_W == 0) else $error("LANES must be a multiple of PASS_W");
      assert (SAVE_DEPTH >= 4) else $error("SAVE_DEPTH below 4 cannot nest conditions");
   end

   logic [LANES-1:0] saved_sel, mask_nxt;
   logic             mask_we, flag_we, save_we, test_req;

   exec_mask_alu #(.LANES(LANES)) u_alu (
      .valid(op_valid), .op(op_code), .cur(exec_mask), .saved(saved_sel),
      .cmp(cmp_mask), .nxt(mask_nxt), .mask_we(mask_we), .flag_we(flag_we),
      .save_we(save_we), .test_req(test_req)
   );

   exec_save_file #(.LANES(LANES), .DEPTH(SAVE_DEPTH), .SLOT_W(SLOT_W)) u_save (
      .clk(clk), .rst_n(rst_n), .we(save_we), .wslot(op_slot), .wdata(exec_mask),
      .rslot_a(op_slot), .rdata_a(saved_sel), .rslot_b(rd_slot), .rdata_b(rd_mask)
   );

   exec_pass_seq #(.LANES(LANES), .PASS_W(PASS_W), .NPASS(NPASS), .IW(IW)) u_pass (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .mask(exec_mask),
      .busy(wr_busy), .idx(pass_idx), .lane_we(lane_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exec_mask   <= '1;
         scc         <= 1'b0;
         branch_take <= 1'b0;
      end else begin
         if (mask_we) exec_mask <= mask_nxt;
         if (flag_we) scc <= |mask_nxt;
         branch_take <= test_req && (exec_mask == '0);
      end
   end
endmodule

// File: rtl/exec_mask_chk.sv
module exec_mask_chk import exec_mask_pkg::*; #(
   parameter int LANES  = 64,
   parameter int PASS_W = 16,
   parameter int IW     = 2,
   parameter int NPASS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_code,
   input logic [LANES-1:0]  exec_mask,
   input logic              scc,
   input logic              branch_take,
   input logic              wr_busy,
   input logic [IW-1:0]     pass_idx,
   input logic [PASS_W-1:0] lane_we
);
   a_r9_idle_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_busy |-> lane_we == '0);

   a_r8_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && pass_idx != IW'(NPASS-1)) |=> (wr_busy && pass_idx == $past(pass_idx) + 1'b1));

   a_r8_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && pass_idx == IW'(NPASS-1)) |=> !wr_busy);

   a_r7_take_cause: assert property (@(posedge clk) disable iff (!rst_n)
      branch_take |-> $past(op_valid && op_code == 3'd5));

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(exec_mask) && $stable(scc)));

   a_r3_flag_save: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1) |=> (scc == (exec_mask != '0)));

   a_r3_flag_andn: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd2) |=> (scc == (exec_mask != '0)));
endmodule

bind exec_mask_ctrl exec_mask_chk #(
   .LANES(LANES), .PASS_W(PASS_W), .IW(IW), .NPASS(NPASS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .exec_mask(exec_mask), .scc(scc), .branch_take(branch_take),
   .wr_busy(wr_busy), .pass_idx(pass_idx), .lane_we(lane_we)
);

// File: tb/tb_exec_mask_ctrl.sv
module tb_exec_mask_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [1:0]  op_slot = 2'd0;
   logic [63:0] cmp_mask = '0;
   logic [63:0] exec_mask;
   logic        scc, branch_take;
   logic [1:0]  rd_slot = 2'd0;
   logic [63:0] rd_mask;
   logic        wr_start = 1'b0;
   logic        wr_busy;
   logic [1:0]  pass_idx;
   logic [15:0] lane_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   exec_mask_ctrl dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_slot(op_slot), .cmp_mask(cmp_mask), .exec_mask(exec_mask), .scc(scc),
      .branch_take(branch_take), .rd_slot(rd_slot), .rd_mask(rd_mask),
      .wr_start(wr_start), .wr_busy(wr_busy), .pass_idx(pass_idx), .lane_we(lane_we)
   );

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  slot;
      logic [63:0] cmp;
      logic [63:0] exp_mask;
      logic        exp_scc;
   } vec_t;

   localparam logic [63:0] M0 = 64'h00FF_00FF_0F0F_F0F0;
   localparam logic [63:0] M1 = 64'h0000_00FF_0F0F_0000;

   localparam vec_t VECS [10] = '{
      '{3'd4, 2'd0, M0,                     M0,    1'b0}, // R6 load, R3 flag kept
      '{3'd1, 2'd0, 64'h0000_FFFF_FFFF_0000, M1,    1'b1}, // R2 if-part
      '{3'd1, 2'd1, 64'h0000_0000_0000_FFFF, 64'h0, 1'b0}, // R2 nested, empty
      '{3'd2, 2'd1, 64'h0,                  M1,    1'b1}, // R4 else-part
      '{3'd3, 2'd0, 64'h0,                  M0,    1'b1}, // R5 restore
      '{3'd2, 2'd0, 64'h0,                  64'h0, 1'b0}, // R4 empty else
      '{3'd3, 2'd0, 64'h0,                  M0,    1'b0}, // R5
      '{3'd1, 2'd2, '1,                     M0,    1'b1}, // R2 all lanes
      '{3'd1, 2'd3, 64'h8000_0000_0000_0001, 64'h0, 1'b0}, // R2 disjoint
      '{3'd0, 2'd0, '1,                     64'h0, 1'b0}  // R11 code 0
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [1:0] slot, input logic [63:0] cmp);
      @(negedge clk);
      op_valid = 1'b1; op_code = op; op_slot = slot; cmp_mask = cmp;
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd0; cmp_mask = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 mask", exec_mask, '1);
      chk("R1 scc", {63'd0, scc}, 64'd0);
      chk("R1 take", {63'd0, branch_take}, 64'd0);
      chk("R1 busy", {63'd0, wr_busy}, 64'd0);
      chk("R1 we", {48'd0, lane_we}, 64'd0);
      for (int s = 0; s < 4; s++) begin
         rd_slot = 2'(s); #1;
         chk("R1 slot", rd_mask, 64'd0);
      end

      foreach (VECS[i]) begin
         apply(VECS[i].op, VECS[i].slot, VECS[i].cmp);
         chk($sformatf("R2-R6 vec%0d mask", i), exec_mask, VECS[i].exp_mask);
         chk($sformatf("R3 vec%0d scc", i), {63'd0, scc}, {63'd0, VECS[i].exp_scc});
      end

      // R12 slot contents after the nested sequence
      rd_slot = 2'd0; #1; chk("R12 slot0", rd_mask, M0);
      rd_slot = 2'd1; #1; chk("R12 slot1", rd_mask, M1);
      rd_slot = 2'd2; #1; chk("R12 slot2", rd_mask, M0);
      rd_slot = 2'd3; #1; chk("R12 slot3", rd_mask, M0);

      // R7 test on empty mask: one-cycle pulse
      apply(3'd5, 2'd0, '0);
      chk("R7 take empty", {63'd0, branch_take}, 64'd1);
      @(negedge clk);
      chk("R7 pulse ends", {63'd0, branch_take}, 64'd0);

      // R11 op_valid low with a real code
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd4; cmp_mask = '1;
      @(negedge clk);
      op_code = 3'd0; cmp_mask = '0;
      chk("R11 invalid ignored", exec_mask, 64'd0);

      // R7 test on nonempty mask
      apply(3'd4, 2'd0, 64'hDEAD_BEEF_0123_4567);
      apply(3'd5, 2'd0, '0);
      chk("R7 take nonempty", {63'd0, branch_take}, 64'd0);

      // R8, R10 passes; the load in the start cycle must not affect the snapshot
      @(negedge clk);
      wr_start = 1'b1; op_valid = 1'b1; op_code = 3'd4; cmp_mask = '0;
      @(negedge clk);
      wr_start = 1'b0; op_valid = 1'b0; op_code = 3'd0;
      chk("R8 busy", {63'd0, wr_busy}, 64'd1);
      chk("R8 idx0", {62'd0, pass_idx}, 64'd0);
      chk("R8 pass0", {48'd0, lane_we}, 64'h4567);
      wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      chk("R8 idx1", {62'd0, pass_idx}, 64'd1);
      chk("R8 pass1", {48'd0, lane_we}, 64'h0123);
      @(negedge clk);
      chk("R10 restart ignored", {62'd0, pass_idx}, 64'd2);
      chk("R8 pass2", {48'd0, lane_we}, 64'hBEEF);
      @(negedge clk);
      chk("R8 pass3", {48'd0, lane_we}, 64'hDEAD);
      @(negedge clk);
      chk("R8 done", {63'd0, wr_busy}, 64'd0);
      chk("R9 idle we", {48'd0, lane_we}, 64'd0);

      // R9 zero mask gives no enables in any pass
      @(negedge clk);
      wr_start = 1'b1;
      @(negedge clk);
      wr_start = 1'b0;
      for (int p = 0; p < 4; p++) begin
         chk("R9 masked lanes", {48'd0, lane_we}, 64'd0);
         @(negedge clk);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule